// File: doc/BRIEF.md
# DAC Code Limiter with Direct Load

This block sits between a stream of 16-bit unsigned host audio samples and the digital code input of a DAC. A 16-bit limit, held in two byte-wide registers, sets an upper bound on the code. Every valid sample that is above the limit is replaced by the limit. Every other sample goes through unchanged. The DAC code is registered, so it changes one clock after a valid sample.

The same two limit registers have a second use. A separate mode register is shared with unrelated functions. When the upper nibble of that mode register holds the load pattern, clearing a trigger bit in the control register copies the current limit value straight into the DAC code. Firmware uses this at power-up to park the amplifier at mid-scale and so avoid a speaker pop. It enters the load mode, writes 0x00 and 0x80 into the limit bytes, sets and then clears the trigger, and finally puts the mode register back. Outside the load mode the trigger has no effect on the DAC code.

All registers sit on a byte bus with one address, a write strobe and combinational read data.

Top module: `dac_limit_front`

## Requirements
- R1: After reset, `dac_code` is 0x8000. The limit reads back as 0x8000 (low byte 0x00, high byte 0x80). The control register and the mode register both read 0x00.
- R2: A write to address 0x2D (limit bits 7:0) or 0x2E (limit bits 15:8) takes effect on the clock edge where `wr_en` is high. `rd_data` returns the addressed register in the same cycle, without a clock.
- R3: The control register at 0x2F stores only bit 3, the trigger. Every other bit reads 0, whatever was written.
- R4: When `sample_valid` is high and `sample` is less than or equal to the limit, `dac_code` equals `sample` after the next clock edge.
- R5: When `sample_valid` is high and `sample` is greater than the limit (unsigned compare), `dac_code` equals the limit after the next clock edge.
- R6: With no valid sample and no direct load, `dac_code` keeps its value.
- R7: The mode register is at address 0x34. When its bits 7:4 equal 4'b0101, a write that clears a set trigger causes a direct load. After the clock edge that follows that write's edge, `dac_code` equals the limit value.
- R8: While bits 7:4 of the mode register differ from 4'b0101, setting and clearing the trigger leaves `dac_code` unchanged.
- R9: One set followed by one clear gives exactly one load. Setting the trigger, holding it high, or writing it low while it is already low loads nothing.
- R10: When a direct load and a valid sample fall in the same cycle, the direct load wins and `dac_code` takes the limit.
- R11: The mode register stores and reads back all 8 bits. Only its bits 7:4 affect this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register byte address, used for both reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| sample_valid | input | 1 | Host sample is valid this cycle |
| sample | input | 16 | Unsigned host sample |
| dac_code | output | 16 | Registered code sent to the DAC |

## Verification
The assertions take three things for granted. First, `addr`, `sample` and `sample_valid` are never unknown while reset is low. Second, the trigger bit changes only through bus writes. Third, every register write is a single-cycle strobe that is set up before the sampling edge. The stimulus meets all three. It changes every input half a period away from the active edge and keeps `addr` at a defined value even when idle. It reaches the trigger only through ordinary writes to the control register, in some cases on back-to-back cycles, so that the case of a set followed at once by a clear is covered.

// File: rtl/dlf_pkg.sv
package dlf_pkg;
   localparam int unsigned DLF_BYTE_W      = 8;
   localparam logic [7:0]  DLF_LIMIT_BASE  = 8'h2D;
   localparam logic [7:0]  DLF_CTRL_ADDR   = 8'h2F;
   localparam logic [7:0]  DLF_MODE_ADDR   = 8'h34;
   localparam int unsigned DLF_TRIG_BIT    = 3;
   localparam logic [3:0]  DLF_LOAD_PAT    = 4'b0101;
   localparam logic [15:0] DLF_RESET_CODE  = 16'h8000;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } dlf_edge_e;
endpackage

// File: rtl/dlf_regfile.sv
module dlf_regfile
   import dlf_pkg::*;
#(
   parameter int unsigned      DATA_W     = 16,
   parameter int unsigned      ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] LIMIT_BASE = ADDR_W'(DLF_LIMIT_BASE),
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(DLF_CTRL_ADDR),
   parameter logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'(DLF_MODE_ADDR),
   parameter int unsigned      TRIG_BIT   = DLF_TRIG_BIT,
   parameter logic [DATA_W-1:0] RESET_CODE = DATA_W'(DLF_RESET_CODE)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  wr_en,
   input  logic [DLF_BYTE_W-1:0] wr_data,
   output logic [DLF_BYTE_W-1:0] rd_data,
   output logic [DATA_W-1:0]     limit_val,
   output logic                  trig_bit,
   output logic [3:0]            mode_sel
);
   localparam int unsigned NUM_LANES = DATA_W / DLF_BYTE_W;
   localparam int unsigned LAST_LANE = 32'(LIMIT_BASE) + NUM_LANES - 1;

   if (DATA_W % DLF_BYTE_W != 0 || DATA_W < DLF_BYTE_W) begin : g_bad_width
      $error("dlf_regfile: DATA_W must be a whole number of bytes");
   end
   if (TRIG_BIT >= DLF_BYTE_W) begin : g_bad_trig
      $error("dlf_regfile: TRIG_BIT outside the control byte");
   end
   if ((32'(CTRL_ADDR) >= 32'(LIMIT_BASE) && 32'(CTRL_ADDR) <= LAST_LANE) ||
       (32'(MODE_ADDR) >= 32'(LIMIT_BASE) && 32'(MODE_ADDR) <= LAST_LANE) ||
       (CTRL_ADDR == MODE_ADDR)) begin : g_bad_map
      $error("dlf_regfile: register addresses overlap");
   end

   logic [DLF_BYTE_W-1:0] lane_q [NUM_LANES];
   logic [NUM_LANES-1:0]  lane_hit;
   logic                  trig_q;
   logic [DLF_BYTE_W-1:0] mode_q;
   logic                  ctrl_hit;
   logic                  mode_hit;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      assign lane_hit[g] = (addr == ADDR_W'(32'(LIMIT_BASE) + g));
      assign limit_val[DLF_BYTE_W*g +: DLF_BYTE_W] = lane_q[g];
   end

   assign ctrl_hit = (addr == CTRL_ADDR);
   assign mode_hit = (addr == MODE_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_LANES; i++) begin
            lane_q[i] <= RESET_CODE[DLF_BYTE_W*i +: DLF_BYTE_W];
         end
      end else if (wr_en) begin
         for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_hit[i]) begin
               lane_q[i] <= wr_data;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         trig_q <= 1'b0;
         mode_q <= '0;
      end else if (wr_en) begin
         if (ctrl_hit) begin
            trig_q <= wr_data[TRIG_BIT];
         end
         if (mode_hit) begin
            mode_q <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_LANES; i++) begin
         if (lane_hit[i]) begin
            rd_data = lane_q[i];
         end
      end
      if (ctrl_hit) begin
         rd_data[TRIG_BIT] = trig_q;
      end
      if (mode_hit) begin
         rd_data = mode_q;
      end
   end

   assign trig_bit = trig_q;
   assign mode_sel = mode_q[DLF_BYTE_W-1 -: 4];
endmodule

// File: rtl/dlf_edge_det.sv
module dlf_edge_det
   import dlf_pkg::*;
#(
   parameter dlf_edge_e POLARITY = EDGE_FALL
) (
   input  logic clk,
   input  logic rst,
   input  logic level,
   output logic pulse
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= 1'b0;
      end else begin
         level_q <= level;
      end
   end

   if (POLARITY == EDGE_FALL) begin : g_fall
      assign pulse = level_q & ~level;
   end else begin : g_rise
      assign pulse = ~level_q & level;
   end
endmodule

// File: rtl/dlf_clamp_stage.sv
module dlf_clamp_stage #(
   parameter int unsigned       DATA_W     = 16,
   parameter logic [DATA_W-1:0] RESET_CODE = 16'h8000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sample_valid,
   input  logic [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0] limit_val,
   input  logic              load,
   output logic [DATA_W-1:0] code
);
   if (DATA_W < 2) begin : g_bad_width
      $error("dlf_clamp_stage: DATA_W too small");
   end

   logic [DATA_W-1:0] bounded;
   logic              over;

   assign over    = (sample > limit_val);
   assign bounded = over ? limit_val : sample;

   always_ff @(posedge clk) begin
      if (rst) begin
         code <= RESET_CODE;
      end else if (load) begin
         code <= limit_val;
      end else if (sample_valid) begin
         code <= bounded;
      end
   end
endmodule

// File: rtl/dac_limit_front.sv
module dac_limit_front
   import dlf_pkg::*;
#(
   parameter int unsigned       DATA_W     = 16,
   parameter int unsigned       ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] LIMIT_BASE = ADDR_W'(DLF_LIMIT_BASE),
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(DLF_CTRL_ADDR),
   parameter logic [ADDR_W-1:0] MODE_ADDR  = ADDR_W'(DLF_MODE_ADDR),
   parameter int unsigned       TRIG_BIT   = DLF_TRIG_BIT,
   parameter logic [3:0]        LOAD_PAT   = DLF_LOAD_PAT,
   parameter logic [DATA_W-1:0] RESET_CODE = DATA_W'(DLF_RESET_CODE)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   input  logic              sample_valid,
   input  logic [DATA_W-1:0] sample,
   output logic [DATA_W-1:0] dac_code
);
   logic [DATA_W-1:0] limit_val;
   logic              trig_bit;
   logic [3:0]        mode_sel;
   logic              mode_on;
   logic              trig_fall;
   logic              load;

   dlf_regfile #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .LIMIT_BASE (LIMIT_BASE),
      .CTRL_ADDR  (CTRL_ADDR),
      .MODE_ADDR  (MODE_ADDR),
      .TRIG_BIT   (TRIG_BIT),
      .RESET_CODE (RESET_CODE)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .addr      (addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .limit_val (limit_val),
      .trig_bit  (trig_bit),
      .mode_sel  (mode_sel)
   );

   dlf_edge_det #(
      .POLARITY (EDGE_FALL)
   ) u_trig_edge (
      .clk   (clk),
      .rst   (rst),
      .level (trig_bit),
      .pulse (trig_fall)
   );

   assign mode_on = (mode_sel == LOAD_PAT);
   assign load    = trig_fall & mode_on;

   dlf_clamp_stage #(
      .DATA_W     (DATA_W),
      .RESET_CODE (RESET_CODE)
   ) u_clamp (
      .clk          (clk),
      .rst          (rst),
      .sample_valid (sample_valid),
      .sample       (sample),
      .limit_val    (limit_val),
      .load         (load),
      .code         (dac_code)
   );
endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h2F,
   parameter int unsigned       TRIG_BIT  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        rd_data,
   input logic              sample_valid,
   input logic [DATA_W-1:0] sample,
   input logic [DATA_W-1:0] dac_code,
   input logic [DATA_W-1:0] limit_val,
   input logic              trig_bit,
   input logic              mode_on
);
   localparam logic [7:0] OTHER_BITS = ~(8'(1) << TRIG_BIT);

   function automatic logic [DATA_W-1:0] bound(input logic [DATA_W-1:0] s,
                                               input logic [DATA_W-1:0] l);
      return (s > l) ? l : s;
   endfunction

   // R4 and R5: a sample with no load in the same cycle is passed through or bounded
   a_r5_clamp: assert property (@(posedge clk) disable iff (rst)
      (sample_valid && !($fell(trig_bit) && mode_on))
      |=> dac_code == bound($past(sample), $past(limit_val)));

   // R6: no sample and no load leaves the code alone
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (!sample_valid && !($fell(trig_bit) && mode_on)) |=> $stable(dac_code));

   // R7: a trigger fall in load mode copies the limit
   a_r7_direct_load: assert property (@(posedge clk) disable iff (rst)
      ($fell(trig_bit) && mode_on) |=> dac_code == $past(limit_val));

   // R8: a trigger fall outside load mode changes nothing
   a_r8_no_effect: assert property (@(posedge clk) disable iff (rst)
      ($fell(trig_bit) && !mode_on && !sample_valid) |=> $stable(dac_code));

   // R10: load wins over a simultaneous sample
   a_r10_load_priority: assert property (@(posedge clk) disable iff (rst)
      ($fell(trig_bit) && mode_on && sample_valid) |=> dac_code == $past(limit_val));

   // R3: the unused control bits read as zero
   a_r3_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
      (addr == CTRL_ADDR) |-> ((rd_data & OTHER_BITS) == 8'h00));
endmodule

bind dac_limit_front dlf_checker #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (CTRL_ADDR),
   .TRIG_BIT  (TRIG_BIT)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .addr         (addr),
   .rd_data      (rd_data),
   .sample_valid (sample_valid),
   .sample       (sample),
   .dac_code     (dac_code),
   .limit_val    (limit_val),
   .trig_bit     (trig_bit),
   .mode_on      (mode_on)
);

// File: tb/dac_limit_front_test.sv
`timescale 1ns/1ps
module dac_limit_front_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  addr = 8'h00;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic        sample_valid = 1'b0;
   logic [15:0] sample = 16'h0000;
   logic [15:0] dac_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // behavioural reference state
   int m_lim;
   int m_trig;
   int m_mode;
   int m_dac;
   bit m_pend;

   always #2.5 clk = ~clk;

   dac_limit_front uut (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .sample_valid(sample_valid), .sample(sample),
      .dac_code(dac_code)
   );

   function automatic int mread(input int a);
      case (a)
         'h2D: return m_lim & 'hFF;
         'h2E: return (m_lim >> 8) & 'hFF;
         'h2F: return m_trig << 3;
         'h34: return m_mode;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_lim = 'h8000; m_trig = 0; m_mode = 0; m_dac = 'h8000; m_pend = 0;
   endtask

   // one clock: drive, check read data, step model at the edge, check dac code
   task automatic cyc(input string tag, input int a, input bit we, input int wd,
                      input bit sv, input int s);
      int nxt;
      bit npend;
      addr = 8'(a); wr_en = we; wr_data = 8'(wd); sample_valid = sv; sample = 16'(s);
      #1;
      chk(tag, "rd_data", int'(rd_data), mread(a));
      @(posedge clk);
      nxt = m_dac;
      if (m_pend && ((m_mode >> 4) == 5)) nxt = m_lim;
      else if (sv) nxt = (s > m_lim) ? m_lim : s;
      npend = we && (a == 'h2F) && (m_trig == 1) && (((wd >> 3) & 1) == 0);
      if (we) begin
         if (a == 'h2D) m_lim = (m_lim & 'hFF00) | (wd & 'hFF);
         if (a == 'h2E) m_lim = (m_lim & 'h00FF) | ((wd & 'hFF) << 8);
         if (a == 'h2F) m_trig = (wd >> 3) & 1;
         if (a == 'h34) m_mode = wd & 'hFF;
      end
      m_dac = nxt;
      m_pend = npend;
      @(negedge clk);
      chk(tag, "dac_code", int'(dac_code), m_dac);
   endtask

   task automatic wr(input string tag, input int a, input int d);
      cyc(tag, a, 1'b1, d, 1'b0, 0);
   endtask

   task automatic smp(input string tag, input int s);
      cyc(tag, 'h2F, 1'b0, 0, 1'b1, s);
   endtask

   task automatic idle(input string tag, input int a);
      cyc(tag, a, 1'b0, 0, 1'b0, 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state, read every register
      idle("R1", 'h2D); idle("R1", 'h2E); idle("R1", 'h2F); idle("R1", 'h34);
      chk("R1", "dac_code at reset", int'(dac_code), 'h8000);

      // R2 limit bytes
      wr("R2", 'h2D, 'h34); wr("R2", 'h2E, 'h12);
      idle("R2", 'h2D); idle("R2", 'h2E);
      // R3 control register keeps only the trigger
      wr("R3", 'h2F, 'hF7); idle("R3", 'h2F);
      wr("R3", 'h2F, 'hFF); idle("R3", 'h2F);
      wr("R3", 'h2F, 'h00); idle("R3", 'h2F);
      // R11 mode register full byte
      wr("R11", 'h34, 'hA7); idle("R11", 'h34);
      wr("R11", 'h34, 'h0F); idle("R11", 'h34);

      // R4 / R5 against limit 0x1234
      smp("R4", 'h1000); smp("R4", 'h1234); smp("R5", 'h1235);
      smp("R5", 'hFFFF); smp("R4", 'h0000);
      // R6 hold
      idle("R6", 'h00); idle("R6", 'h2D); idle("R6", 'h2E);

      // R8 trigger outside load mode
      wr("R8", 'h34, 'h53 ^ 'h10); wr("R8", 'h2F, 'h08); wr("R8", 'h2F, 'h00);
      idle("R8", 'h2F); idle("R8", 'h2F);

      // R7 / R9 power-up style sequence
      wr("R7", 'h34, 'h53);
      wr("R7", 'h2D, 'h00); wr("R7", 'h2E, 'h80);
      wr("R9", 'h2F, 'h08); wr("R7", 'h2F, 'h00);
      idle("R7", 'h2F); wr("R7", 'h34, 'h03); idle("R9", 'h34); idle("R9", 'h00);

      // R9 trigger held high and a redundant clear
      wr("R9", 'h34, 'h5C); wr("R9", 'h2E, 'h44);
      wr("R9", 'h2F, 'h08); idle("R9", 'h2F); idle("R9", 'h2F); wr("R9", 'h2F, 'h08);
      idle("R9", 'h2F);
      wr("R9", 'h2F, 'h00); idle("R9", 'h2F); wr("R9", 'h2F, 'h00); idle("R9", 'h2F);
      smp("R4", 'h0123);
      wr("R9", 'h2F, 'h00); idle("R9", 'h00); idle("R9", 'h00);

      // R10 load and sample together
      wr("R10", 'h2D, 'h77); wr("R10", 'h2F, 'h08); wr("R10", 'h2F, 'h00);
      smp("R10", 'h0001); smp("R4", 'h0002);
      wr("R10", 'h34, 'h00);

      // R5 boundaries: limit all ones and all zeros
      wr("R5", 'h2D, 'hFF); wr("R5", 'h2E, 'hFF);
      smp("R4", 'hFFFF); smp("R4", 'hFFFE);
      wr("R5", 'h2D, 'h00); wr("R5", 'h2E, 'h00);
      smp("R5", 'h0001); smp("R4", 'h0000); smp("R5", 'h8000);

      // mixed traffic
      wr("R2", 'h2E, 'h9A); wr("R2", 'h2D, 'hBC);
      for (int i = 0; i < 300; i++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 6) smp("R5", int'($urandom_range(0, 'hFFFF)));
         else if (r == 6) wr("R2", 'h2D + int'($urandom_range(0, 1)), int'($urandom_range(0, 255)));
         else if (r == 7) wr("R7", 'h2F, ($urandom_range(0, 1) != 0) ? 'h08 : 'h00);
         else if (r == 8) wr("R11", 'h34, ($urandom_range(0, 1) != 0) ? 'h5A : 'h3A);
         else idle("R6", int'($urandom_range('h2C, 'h35)));
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule